// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Controller

This block is a three-wire synchronous serial port with a chip select. A control bit chooses its role. As master it makes the shift clock from the system clock through a programmable divider, and a write to its data register starts a transfer. As slave it follows a clock and a select driven from outside. A single shift engine serves both roles. The two data pins swap direction when the role changes, so the same pair of board wires works either way.

Each transfer moves 8 or 16 bits, most significant bit first. The clock can idle low or high. A clocking-mode bit decides whether input is sampled on the leading or the trailing clock edge. A finished word goes into a read buffer. A busy flag, a buffer-full flag and an overrun flag can be polled, and each one also drives its own interrupt line. In slave mode the block can echo its input pin straight back onto its output pin, and it drives a ready line that tells the remote master when another word can be taken.

Software uses a small register port with three addresses. Address 0 is data: a write loads the transmit word and a read returns the read buffer. Address 1 is control. Address 2 is status, with busy in bit 0, full in bit 1 and overrun in bit 2.

Top module: `sync_serial_ctl`

## Requirements
- R1: After reset, status reads 0, control reads 0 (slave role), the shift clock output is low, the ready output is high and all interrupt lines are low.
- R2: Control bit 0 set selects master. A data write then shifts 8 bits (control bit 1 clear) or 16 bits (bit 1 set). Each clock half-period lasts N+1 system clocks, where N is control bits 15:8. The received word is readable at address 0, and in 8-bit mode the upper byte is zero.
- R3: Data is sent most significant bit first: bit 7 in 8-bit mode, bit 15 in 16-bit mode.
- R4: Control bit 2 sets the clock idle level. When no master transfer is running, the shift clock output equals that bit.
- R5: Control bit 3 clear samples input on the leading edge (the edge leaving idle). Set, it samples on the trailing edge and changes output on the leading edge. A master loopback from output pin B to input pin A returns the sent word in both modes.
- R6: Status bit 0 (busy) is 1 from the starting write until the last bit has shifted. A data write while busy is ignored.
- R7: Completing a word copies it into the read buffer and sets status bit 1 (full). Reading address 0 clears full.
- R8: If full is still set when a word completes, status bit 2 (overrun) is set and the older word is kept. Writing status with bit 2 set clears overrun.
- R9: If a read of address 0 falls in the same cycle as a completion, the read returns the older word, the new word is stored, full stays set and overrun stays clear.
- R10: In slave role, pin A is the output (driven while the select is low) and pin B is the input. The shift clock output is not driven. The block receives the incoming word and sends the word last written to address 0, MSB first, in both clocking modes.
- R11: In slave role with control bit 4 (echo) set, pin A follows pin B directly.
- R12: In slave role, the ready output is low while full is set and no new transmit word has been written since the last completed transfer. Otherwise it is high.
- R13: Interrupt lines busy, full and overrun are the matching status flags gated by control bits 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe (reading address 0 clears full) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data |
| sel_n | input | 1 | Slave select, active low |
| sck_in | input | 1 | Shift clock from a remote master |
| sck_out | output | 1 | Shift clock in master role |
| sck_oe | output | 1 | Shift clock drive enable |
| pin_a_in | input | 1 | Pin A input (master serial in) |
| pin_a_out | output | 1 | Pin A output (slave serial out) |
| pin_a_oe | output | 1 | Pin A drive enable |
| pin_b_in | input | 1 | Pin B input (slave serial in) |
| pin_b_out | output | 1 | Pin B output (master serial out) |
| pin_b_oe | output | 1 | Pin B drive enable |
| slv_rdy | output | 1 | Slave ready handshake |
| irq_busy | output | 1 | Busy interrupt |
| irq_full | output | 1 | Buffer-full interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
Two functions can land in the same clock edge: completion of a word, and a software read of the buffer that clears full. The bench loads a first word and leaves it unread. It then starts a second master transfer with divider 0, counts the exact number of clocks until the last shift edge, and raises the read strobe for that edge. A correct design returns the first word on that read, then shows full set with overrun clear, and returns the second word on the next read. Any design that lets the read lose to the completion shows a spurious overrun or the wrong word.

// File: rtl/sync_serial_ctl.sv
module sync_serial_ctl #(
  parameter int DW   = 16,
  parameter int DIVW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          sel_n,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          pin_a_in,
  output logic          pin_a_out,
  output logic          pin_a_oe,
  input  logic          pin_b_in,
  output logic          pin_b_out,
  output logic          pin_b_oe,
  output logic          slv_rdy,
  output logic          irq_busy,
  output logic          irq_full,
  output logic          irq_ovr
);
  localparam int HW  = DW / 2;
  localparam int CW  = $clog2(2 * DW);
  localparam int CTW = 8 + DIVW;
  localparam logic [CW-1:0] LAST_W = CW'(2 * DW - 1);
  localparam logic [CW-1:0] LAST_N = CW'(2 * HW - 1);
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

  logic [7:0]      ctl_q;
  logic [DIVW-1:0] div_q, div_cnt;
  logic [DW-1:0]   sr_q, rbuf_q, sr_nx, word;
  logic [CW-1:0]   edg_q;
  logic            busy_q, full_q, ovr_q, ph_q, hold_q, dout_q, txp_q;
  logic [2:0]      sck_sy;
  logic [1:0]      din_sy, sel_sy;

  logic is_mst, wide, idle_hi, late, echo;
  assign is_mst  = ctl_q[0];
  assign wide    = ctl_q[1];
  assign idle_hi = ctl_q[2];
  assign late    = ctl_q[3];
  assign echo    = ctl_q[4];

  logic m_tick, s_act, s_now, s_old, lead, trail, din, bit_in, msb, dout, done, rd_clr, wr_dat, s_idle;
  assign m_tick = is_mst && busy_q && (div_cnt == div_q);
  assign s_act  = !is_mst && !sel_sy[1];
  assign s_idle = !is_mst && sel_sy[1];
  assign s_now  = sck_sy[1] ^ idle_hi;
  assign s_old  = sck_sy[2] ^ idle_hi;
  assign lead   = m_tick ? !ph_q : (s_act && s_now && !s_old);
  assign trail  = m_tick ? ph_q  : (s_act && !s_now && s_old);
  assign din    = is_mst ? pin_a_in : din_sy[1];
  assign bit_in = late ? din : hold_q;
  assign sr_nx  = {sr_q[DW-2:0], bit_in};
  assign word   = wide ? sr_nx : {{(DW-HW){1'b0}}, sr_nx[HW-1:0]};
  assign msb    = wide ? sr_q[DW-1] : sr_q[HW-1];
  assign dout   = late ? dout_q : msb;
  assign done   = trail && (edg_q == (wide ? LAST_W : LAST_N));
  assign rd_clr = rd_en && (rd_addr == A_DATA);
  assign wr_dat = wr_en && (wr_addr == A_DATA) && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      din_sy <= '0;
      sel_sy <= '1;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      din_sy <= {din_sy[0], pin_b_in};
      sel_sy <= {sel_sy[0], sel_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      div_q   <= '0;
      div_cnt <= '0;
      sr_q    <= '0;
      rbuf_q  <= '0;
      edg_q   <= '0;
      busy_q  <= 1'b0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      ph_q    <= 1'b0;
      hold_q  <= 1'b0;
      dout_q  <= 1'b0;
      txp_q   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL && !busy_q) {div_q, ctl_q} <= wr_data[CTW-1:0];
      if (wr_en && wr_addr == A_STAT && wr_data[2]) ovr_q <= 1'b0;
      if (rd_clr) full_q <= 1'b0;
      if (wr_dat) begin
        sr_q  <= wr_data;
        txp_q <= 1'b1;
        if (is_mst) begin
          busy_q  <= 1'b1;
          div_cnt <= '0;
          edg_q   <= '0;
          ph_q    <= 1'b0;
        end
      end
      if (is_mst && busy_q) div_cnt <= m_tick ? '0 : div_cnt + 1'b1;
      if (m_tick) ph_q <= !ph_q;
      if (lead) begin
        edg_q <= edg_q + 1'b1;
        if (!is_mst) busy_q <= 1'b1;
        if (late) dout_q <= msb;
        else      hold_q <= din;
      end
      if (trail) begin
        edg_q <= edg_q + 1'b1;
        sr_q  <= sr_nx;
      end
      if (done) begin
        busy_q <= 1'b0;
        edg_q  <= '0;
        txp_q  <= 1'b0;
        if (full_q && !rd_clr) ovr_q <= 1'b1;
        else begin
          rbuf_q <= word;
          full_q <= 1'b1;
        end
      end
      if (s_idle) begin
        busy_q <= 1'b0;
        edg_q  <= '0;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_DATA:  rd_data = rbuf_q;
      A_CTRL:  rd_data = DW'({div_q, ctl_q});
      A_STAT:  rd_data = DW'({ovr_q, full_q, busy_q});
      default: rd_data = '0;
    endcase
  end

  assign sck_out   = ph_q ^ idle_hi;
  assign sck_oe    = is_mst;
  assign pin_b_out = dout;
  assign pin_b_oe  = is_mst;
  assign pin_a_out = (echo && !is_mst) ? pin_b_in : dout;
  assign pin_a_oe  = !is_mst && !sel_n;
  assign slv_rdy   = is_mst || !(full_q && !txp_q);
  assign irq_busy  = busy_q && ctl_q[5];
  assign irq_full  = full_q && ctl_q[6];
  assign irq_ovr   = ovr_q  && ctl_q[7];
endmodule

// File: rtl/sync_serial_ctl_chk.sv
module sync_serial_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_q,
  input logic       busy_q,
  input logic       full_q,
  input logic       ovr_q,
  input logic       sck_out,
  input logic       slv_rdy,
  input logic       irq_full,
  input logic       irq_ovr
);
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !busy_q) |-> (sck_out == ctl_q[2]));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && $fell(busy_q)) |-> (full_q || ovr_q));

  // R7
  full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(busy_q));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(full_q));

  // R12
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[0] && !slv_rdy) |-> full_q);

  // R13
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovr |-> ovr_q) and (irq_full |-> full_q));
endmodule

bind sync_serial_ctl sync_serial_ctl_chk i_chk (.*);

// File: tb/test_sync_serial_ctl.sv
module test_sync_serial_ctl;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        sel_n = 1, sck_in = 0, pin_b_in = 0;
  logic        sck_out, sck_oe, pin_a_in, pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;
  logic        slv_rdy, irq_busy, irq_full, irq_ovr;

  localparam logic [1:0] AD = 2'd0, AC = 2'd1, AS = 2'd2;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  assign pin_a_in = pin_b_out;

  sync_serial_ctl i_sync_serial_ctl (.*);

  always #5 clk = ~clk;

  logic m_prev = 0, m_idle = 0, m_late = 0;
  int   m_run = 0, m_half = 0, cap_n = 0;
  logic [15:0] cap = 0;

  always @(negedge clk) begin
    if (sck_out !== m_prev) begin
      m_half = m_run;
      m_run = 1;
      if (((sck_out ^ m_idle) == 1'b1) != m_late) begin
        cap = {cap[14:0], pin_b_out};
        cap_n++;
      end
    end else m_run++;
    m_prev = sck_out;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    int g = 0;
    do begin bus_rd(AS, v); g++; end while (v[0] && g < 5000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bus_rd(AS, v);  check(v == 0, "R1 status", v, 0);
    bus_rd(AC, v);  check(v == 0, "R1 control", v, 0);
    check(sck_out == 0, "R1 clock low", sck_out, 0);
    check(slv_rdy == 1, "R1 ready", slv_rdy, 1);
    check({irq_busy, irq_full, irq_ovr} == 0, "R1 irq", {irq_busy, irq_full, irq_ovr}, 0);
  endtask

  task automatic t_master(input bit wide, input bit idle, input bit late, input logic [7:0] dv, input logic [15:0] tx);
    logic [15:0] v, expv, mask;
    int bits;
    bits = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    expv = tx & mask;
    bus_wr(AC, {dv, 3'b111, 1'b0, late, idle, wide, 1'b1});
    m_idle = idle; m_late = late;
    repeat (2) @(negedge clk);
    cap = 0; cap_n = 0;
    bus_wr(AD, tx);
    bus_rd(AS, v); check(v[0] == 1, "R6 busy while shifting", v[0], 1);
    bus_wr(AD, ~tx);
    wait_idle();
    bus_rd(AS, v);
    check(cap_n == bits, "R2 bit count", cap_n, bits);
    check((cap & mask) == expv, "R3 MSB-first order", cap & mask, expv);
    check(m_half == dv + 1, "R2 half period", m_half, dv + 1);
    check(sck_out == idle, "R4 idle level", sck_out, idle);
    check(v[1:0] == 2'b10, "R7 full set busy clear", v[1:0], 2'b10);
    check(irq_full == 1, "R13 full irq", irq_full, 1);
    bus_rd(AD, v); check(v == expv, late ? "R5 trailing-mode data" : "R2 loopback data", v, expv);
    bus_rd(AS, v); check(v[1] == 0, "R7 read clears full", v[1], 0);
  endtask

  task automatic xfer(input logic [15:0] tx);
    bus_wr(AD, tx);
    wait_idle();
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    bus_wr(AC, {8'd0, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
    xfer(16'h005A);
    xfer(16'h00C3);
    bus_rd(AS, v); check(v[2:1] == 2'b11, "R8 overrun set", v[2:1], 2'b11);
    check(irq_ovr == 1, "R13 overrun irq", irq_ovr, 1);
    bus_rd(AD, v); check(v == 16'h005A, "R8 older word kept", v, 16'h005A);
    bus_wr(AS, 16'h0004);
    bus_rd(AS, v); check(v[2] == 0, "R8 write-one clears", v[2], 0);
    xfer(16'h0033);
    bus_wr(AC, {8'd0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
    bus_rd(AS, v);
    check(v[1] == 1 && irq_full == 0, "R13 masked irq", {v[1], irq_full}, 2'b10);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    bus_wr(AD, 16'h0096);
    repeat (15) @(negedge clk);
    rd_en = 1; rd_addr = AD; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
    check(v == 16'h0033, "R9 read returns older", v, 16'h0033);
    bus_rd(AS, v); check(v[2:0] == 3'b010, "R9 full kept no overrun", v[2:0], 3'b010);
    bus_rd(AD, v); check(v == 16'h0096, "R9 new word stored", v, 16'h0096);
  endtask

  task automatic t_slave(input bit wide, input bit idle, input bit late, input logic [15:0] rx, input logic [15:0] tx);
    logic [15:0] v, got, mask;
    int bits;
    bits = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    bus_wr(AC, {8'd0, 3'b111, 1'b0, late, idle, wide, 1'b0});
    sck_in = idle; sel_n = 1;
    bus_wr(AD, tx);
    check(slv_rdy == 1, "R12 ready before", slv_rdy, 1);
    sel_n = 0;
    repeat (4) @(negedge clk);
    check({pin_a_oe, pin_b_oe, sck_oe} == 3'b100, "R10 pin roles", {pin_a_oe, pin_b_oe, sck_oe}, 3'b100);
    got = 0;
    for (int i = bits - 1; i >= 0; i--) begin
      if (!late) begin
        pin_b_in = rx[i];
        repeat (8) @(negedge clk);
        got = {got[14:0], pin_a_out};
        sck_in = ~idle;
        repeat (8) @(negedge clk);
        sck_in = idle;
      end else begin
        sck_in = ~idle;
        pin_b_in = rx[i];
        repeat (8) @(negedge clk);
        got = {got[14:0], pin_a_out};
        sck_in = idle;
        repeat (8) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    sel_n = 1;
    repeat (3) @(negedge clk);
    check((got & mask) == (tx & mask), "R10 slave sends", got & mask, tx & mask);
    check(slv_rdy == 0, "R12 not ready when full", slv_rdy, 0);
    bus_wr(AD, tx);
    check(slv_rdy == 1, "R12 ready after load", slv_rdy, 1);
    bus_rd(AD, v); check(v == (rx & mask), "R10 slave receives", v, rx & mask);
  endtask

  task automatic t_echo();
    bus_wr(AC, 16'h0010);
    sel_n = 0;
    pin_b_in = 1; #1 check(pin_a_out == 1, "R11 echo high", pin_a_out, 1);
    @(negedge clk);
    pin_b_in = 0; #1 check(pin_a_out == 0, "R11 echo low", pin_a_out, 0);
    @(negedge clk);
    sel_n = 1;
    bus_wr(AC, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_master(1'b0, 1'b0, 1'b0, 8'd3, 16'h00B4);
    t_master(1'b1, 1'b1, 1'b0, 8'd1, 16'hC0DE);
    t_master(1'b1, 1'b0, 1'b1, 8'd0, 16'h8E71);
    t_master(1'b0, 1'b1, 1'b1, 8'd2, 16'hFF4D);
    t_overrun();
    t_collide();
    t_slave(1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C);
    t_slave(1'b1, 1'b1, 1'b1, 16'h9B17, 16'h6E2D);
    t_echo();
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule